// File: doc/BRIEF.md
# Packet framing and escape encoder

This block turns a stream of transaction-layer bytes into the byte stream that a serial link shifter sends. Each input byte comes with a flag that marks the final byte of its packet. The block opens every packet with a start marker, a channel marker and a channel number. It then forwards the payload bytes. A byte that collides with a reserved code of either protocol layer becomes a two-byte pair: an escape code followed by the byte XORed with 0x20.

The end-of-packet marker comes one position early, just before the encoding of the final payload byte. A receiver therefore knows that the next data byte closes the packet. With word alignment enabled, idle bytes go in where the end marker would have gone. The end marker and the final byte move to the end of a packet whose total length is a whole number of words. A receiver that reads whole words then cannot see the end of a request before the word carrying it is complete.

Both sides use a byte-wide valid/ready handshake. An input byte is taken only in the cycle in which the last output byte derived from it is accepted.

Top module: `fbx_framer`

## Requirements
- R1: Every packet begins with the three bytes 0x7A, 0x7C and the channel number (parameter CHAN_ID, default 0x00). These are produced only while an input byte is offered.
- R2: A payload byte equal to 0x7A, 0x7B, 0x7C or 0x7D is emitted as 0x7D followed by the byte XOR 0x20.
- R3: A payload byte equal to 0x4A or 0x4D is emitted as 0x4D followed by the byte XOR 0x20.
- R4: While an escape code (0x7D or 0x4D) is accepted at the output, the input is not taken (in_ready low). The byte is consumed with the second byte of the pair.
- R5: Every other payload byte is emitted unchanged, in input order, and is consumed in the same cycle it is accepted at the output.
- R6: The byte 0x7B is emitted once per packet, directly before the encoding of the byte flagged last, which is escaped per R2/R3 when needed. The input is not taken while 0x7B is accepted.
- R7: With ALIGN_EN=1, the fewest idle bytes (0x4A) needed are placed directly before 0x7B so that the packet's total output length is a multiple of WORD_BYTES (default 4). No idle is added when the length is already a multiple.
- R8: out_valid equals in_valid in every cycle. in_ready is never high while out_ready is low.
- R9: After reset out_valid and in_ready are low while no input is offered. The first byte emitted after reset, and after each last byte is consumed, is 0x7A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte consumed this cycle |
| in_data | input | 8 | Transaction-layer byte |
| in_last | input | 1 | Byte is the final one of its packet |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Link side accepts the output byte |
| out_data | output | 8 | Physical-layer byte |

## Verification
The hardest situation to reach is a packet whose final byte needs escaping. Its padding count must then account for a three-byte tail instead of two. This has to happen while the link side stalls in the middle of the idle run or between the escape code and its partner. Random payloads draw heavily from the six reserved codes, and directed packets sweep every length from one to nine bytes, so the final byte and the body length hit every residue of the word size. Random gaps in out_ready then land on each tail position.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
   localparam logic [7:0] K_SOP  = 8'h7A;
   localparam logic [7:0] K_EOP  = 8'h7B;
   localparam logic [7:0] K_CHAN = 8'h7C;
   localparam logic [7:0] K_PESC = 8'h7D;
   localparam logic [7:0] K_IDLE = 8'h4A;
   localparam logic [7:0] K_YESC = 8'h4D;
   localparam logic [7:0] K_FLIP = 8'h20;

   typedef enum logic [3:0] {
      ST_SOP, ST_CHM, ST_CHN, ST_BODY, ST_PAD, ST_EOP, ST_LESC, ST_FLIP, ST_LAST
   } fbx_state_t;

   function automatic logic is_reserved(input logic [7:0] b);
      return (b == K_SOP) || (b == K_EOP) || (b == K_CHAN) || (b == K_PESC) ||
             (b == K_IDLE) || (b == K_YESC);
   endfunction
endpackage

// File: rtl/fbx_classify.sv
module fbx_classify
   import fbx_pkg::*;
(
   input  logic [7:0] byte_i,
   output logic       needs_esc,
   output logic [7:0] esc_code
);
   logic pkt_hit, phy_hit;

   assign pkt_hit   = (byte_i == K_SOP) || (byte_i == K_EOP) ||
                      (byte_i == K_CHAN) || (byte_i == K_PESC);
   assign phy_hit   = (byte_i == K_IDLE) || (byte_i == K_YESC);
   assign needs_esc = pkt_hit || phy_hit;
   assign esc_code  = pkt_hit ? K_PESC : K_YESC;
endmodule

// File: rtl/fbx_align.sv
module fbx_align #(
   parameter int WORD_BYTES = 4,
   parameter bit ALIGN_EN   = 1'b1,
   localparam int CW        = $clog2(WORD_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          out_fire,
   input  logic          pkt_done,
   input  logic          tail_esc,
   output logic [CW-1:0] pad_need
);
   generate
      if (ALIGN_EN) begin : g_align
         logic [CW-1:0] cnt;
         logic [CW-1:0] tail_w;

         assign tail_w   = tail_esc ? CW'(3) : CW'(2);
         assign pad_need = CW'(0) - (cnt + tail_w);

         always_ff @(posedge clk) begin
            if (!rst_n)        cnt <= '0;
            else if (pkt_done) cnt <= '0;
            else if (out_fire) cnt <= cnt + CW'(1);
         end

         // R7: the final byte of a packet fills the last slot of a word
         a_r7_word_filled: assert property (@(posedge clk) disable iff (!rst_n)
            pkt_done |-> (CW'(cnt + CW'(1)) == '0));
      end else begin : g_plain
         assign pad_need = '0;
      end
   endgenerate
endmodule

// File: rtl/fbx_seq.sv
module fbx_seq
   import fbx_pkg::*;
#(
   parameter logic [7:0] CHAN_ID = 8'h00,
   parameter int          CW      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   input  logic          in_last,
   input  logic          out_ready,
   input  logic          needs_esc,
   input  logic [7:0]    esc_code,
   input  logic [CW-1:0] pad_need,
   output logic          in_ready,
   output logic          out_valid,
   output logic [7:0]    out_data
);
   fbx_state_t    st, st_nx;
   logic [CW-1:0] pad_rem, pad_rem_nx;
   logic          take, fire;

   assign fire      = in_valid && out_ready;
   assign out_valid = in_valid;
   assign in_ready  = take && out_ready;

   always_comb begin
      st_nx      = st;
      pad_rem_nx = pad_rem;
      out_data   = in_data;
      take       = 1'b0;
      unique case (st)
         ST_SOP: begin out_data = K_SOP;  st_nx = ST_CHM; end
         ST_CHM: begin out_data = K_CHAN; st_nx = ST_CHN; end
         ST_CHN: begin out_data = CHAN_ID; st_nx = ST_BODY; end
         ST_BODY: begin
            if (in_last) begin
               if (pad_need != '0) begin
                  out_data   = K_IDLE;
                  pad_rem_nx = pad_need - CW'(1);
                  st_nx      = (pad_need == CW'(1)) ? ST_EOP : ST_PAD;
               end else begin
                  out_data = K_EOP;
                  st_nx    = needs_esc ? ST_LESC : ST_LAST;
               end
            end else if (needs_esc) begin
               out_data = esc_code;
               st_nx    = ST_FLIP;
            end else begin
               take = 1'b1;
            end
         end
         ST_PAD: begin
            out_data   = K_IDLE;
            pad_rem_nx = pad_rem - CW'(1);
            if (pad_rem == CW'(1)) st_nx = ST_EOP;
         end
         ST_EOP: begin
            out_data = K_EOP;
            st_nx    = needs_esc ? ST_LESC : ST_LAST;
         end
         ST_LESC: begin out_data = esc_code; st_nx = ST_FLIP; end
         ST_FLIP: begin
            out_data = in_data ^ K_FLIP;
            take     = 1'b1;
            st_nx    = in_last ? ST_SOP : ST_BODY;
         end
         ST_LAST: begin take = 1'b1; st_nx = ST_SOP; end
         default: st_nx = ST_SOP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_SOP;
         pad_rem <= '0;
      end else if (fire) begin
         st      <= st_nx;
         pad_rem <= pad_rem_nx;
      end
   end

   // R4: an escape code never consumes the input byte
   a_r4_esc_holds_input: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (out_data == K_PESC || out_data == K_YESC)) |-> !in_ready);
   // R6: the end marker never consumes the input byte
   a_r6_eop_holds_input: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && out_data == K_EOP) |-> !in_ready);
   // R8: no consumption without link acceptance
   a_r8_ready_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> out_ready);
   // R9: a new packet opens with the start marker
   a_r9_restart_sop: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> (out_data == K_SOP));
   // R7: the idle run never starts from an empty remainder
   a_r7_pad_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PAD) |-> (pad_rem != '0));
endmodule

// File: rtl/fbx_framer.sv
module fbx_framer
   import fbx_pkg::*;
#(
   parameter int          WORD_BYTES = 4,
   parameter bit          ALIGN_EN   = 1'b1,
   parameter logic [7:0]  CHAN_ID    = 8'h00,
   localparam int         CW         = $clog2(WORD_BYTES)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data
);
   generate
      if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two of at least 2");
      end
      if (is_reserved(CHAN_ID)) begin : g_bad_chan
         $error("CHAN_ID must not be a reserved code");
      end
   endgenerate

   logic          needs_esc;
   logic [7:0]    esc_code;
   logic [CW-1:0] pad_need;

   fbx_classify u_cls (
      .byte_i    (in_data),
      .needs_esc (needs_esc),
      .esc_code  (esc_code)
   );

   fbx_align #(.WORD_BYTES(WORD_BYTES), .ALIGN_EN(ALIGN_EN)) u_aln (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_fire (out_valid && out_ready),
      .pkt_done (in_valid && in_ready && in_last),
      .tail_esc (needs_esc),
      .pad_need (pad_need)
   );

   fbx_seq #(.CHAN_ID(CHAN_ID), .CW(CW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_last   (in_last),
      .out_ready (out_ready),
      .needs_esc (needs_esc),
      .esc_code  (esc_code),
      .pad_need  (pad_need),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data)
   );
endmodule

// File: tb/tb_fbx_framer.sv
module tb_fbx_framer;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid, in_ready, in_last;
   logic [7:0] in_data;
   logic       out_valid, out_ready;
   logic [7:0] out_data;

   always #2.5 clk = ~clk;

   fbx_framer dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   int n_cmp = 0, n_bad = 0;
   logic [7:0] ib[$];
   bit         il[$];
   logic [7:0] eb[$];
   string      et[$];
   logic [7:0] pk[0:31];

   function automatic bit pkt_code(input logic [7:0] b);
      return b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D;
   endfunction
   function automatic bit phy_code(input logic [7:0] b);
      return b == 8'h4A || b == 8'h4D;
   endfunction

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push(input logic [7:0] b, input string tag);
      eb.push_back(b);
      et.push_back(tag);
   endtask

   task automatic enc(input logic [7:0] b, input string plain_tag);
      if (pkt_code(b)) begin push(8'h7D, "R2"); push(b ^ 8'h20, "R2"); end
      else if (phy_code(b)) begin push(8'h4D, "R3"); push(b ^ 8'h20, "R3"); end
      else push(b, plain_tag);
   endtask

   task automatic add_pkt(input int n);
      int start = eb.size();
      int len, pad;
      push(8'h7A, "R1"); push(8'h7C, "R1"); push(8'h00, "R1");
      for (int i = 0; i < n; i++) begin
         ib.push_back(pk[i]);
         il.push_back(i == n - 1);
      end
      for (int i = 0; i < n - 1; i++) enc(pk[i], "R5");
      len = eb.size() - start + 2 + ((pkt_code(pk[n-1]) || phy_code(pk[n-1])) ? 1 : 0);
      pad = (4 - (len % 4)) % 4;
      for (int i = 0; i < pad; i++) push(8'h4A, "R7");
      push(8'h7B, "R6");
      enc(pk[n-1], "R6");
   endtask

   function automatic logic [7:0] rbyte();
      logic [7:0] res [0:5] = '{8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h4A, 8'h4D};
      if ($urandom % 5 < 2) return res[$urandom % 6];
      return 8'($urandom);
   endfunction

   initial begin
      int ii = 0, ei = 0, cyc = 0;
      bit hold = 1'b0;
      void'($urandom(32'd20240611));
      // directed: single plain byte, single escaped byte, all reserved codes
      pk[0] = 8'h41; add_pkt(1);
      pk[0] = 8'h7B; add_pkt(1);
      pk[0] = 8'h4D; add_pkt(1);
      pk[0] = 8'h7A; pk[1] = 8'h7B; pk[2] = 8'h7C; pk[3] = 8'h7D; pk[4] = 8'h4A; pk[5] = 8'h4D;
      add_pkt(6);
      pk[0] = 8'h11; pk[1] = 8'h22; pk[2] = 8'h33; pk[3] = 8'h44; add_pkt(4);
      // sweep lengths with biased random bytes
      for (int r = 0; r < 4; r++)
         for (int n = 1; n <= 9; n++) begin
            for (int i = 0; i < n; i++) pk[i] = rbyte();
            add_pkt(n);
         end
      for (int p = 0; p < 40; p++) begin
         int n = 1 + ($urandom % 20);
         for (int i = 0; i < n; i++) pk[i] = rbyte();
         add_pkt(n);
      end

      rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R9", {7'b0, out_valid}, 8'h00);
      check(in_ready == 1'b0 || in_valid, "R9", {7'b0, in_ready}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      while (ei < eb.size()) begin
         @(negedge clk);
         cyc++;
         if (cyc > 100000) begin
            check(1'b0, "watchdog", 8'(ei), 8'(eb.size()));
            break;
         end
         if (!hold) begin
            in_valid = (ii < ib.size()) && ($urandom % 8 != 0);
            if (ii < ib.size()) begin in_data = ib[ii]; in_last = il[ii]; end
         end
         out_ready = ($urandom % 4 != 0);
         #1;
         check(out_valid == in_valid, "R8", {7'b0, out_valid}, {7'b0, in_valid});
         if (in_ready && !out_ready) check(1'b0, "R8", {7'b0, in_ready}, 8'h00);
         if (out_valid && out_ready) begin
            if (ei >= eb.size()) check(1'b0, "R5", out_data, 8'hxx);
            else begin
               check(out_data === eb[ei], et[ei], out_data, eb[ei]);
               if (eb[ei] == 8'h7D || eb[ei] == 8'h4D)
                  check(!in_ready, "R4", {7'b0, in_ready}, 8'h00);
               if (eb[ei] == 8'h7B)
                  check(!in_ready, "R6", {7'b0, in_ready}, 8'h00);
               ei++;
            end
         end
         if (in_valid && in_ready) begin ii++; hold = 1'b0; end
         else hold = in_valid;
      end
      check(ii == ib.size(), "R5", 8'(ii), 8'(ib.size()));
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check(out_valid == 1'b0, "R8", {7'b0, out_valid}, 8'h00);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule